// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit

This block watches 32 general-purpose input pins and turns their transitions into one level-sensitive interrupt for a parent interrupt controller. Each pin is brought into the clock domain through two flip-flops. It is then compared with its value one clock earlier. Each pin can be set to react either to falling transitions only or to any transition. A detected transition sets a sticky per-pin event bit. The interrupt output stays high while any pending event has its pin enabled.

Software uses a single-cycle register port with a write strobe and a combinational read-back. It reads the pending events and clears them by writing ones. It enables or blocks each pin with a mask and picks each pin's edge mode. In every register, pin n sits at bit 31−n, so pin 0 is the most significant bit. A typical start-up writes all ones to the event register and zero to the mask register. This discards stale events and blocks every interrupt before any pin is enabled. The pins should be held low while reset is asserted; otherwise the first rising transition after reset is reported as an event.

Top module: `gpio_edge_irq`

## Requirements
- R1: The block serves 32 pins. Pin n (port bit `gpio_in[n]`) maps to bit 31−n of the event, mask and edge-select registers, so pin 0 is register bit 31.
- R2: Byte offset 0x0 selects the event register, 0x4 the mask register and 0x8 the edge-select register. Mask and edge-select read back what was written. Any other offset reads as zero and ignores writes.
- R3: After reset all three registers read zero and `irq_o` is low.
- R4: A pin whose edge-select bit is 1 records only falling transitions; its rising transitions set no event.
- R5: A pin whose edge-select bit is 0 records both rising and falling transitions.
- R6: A pin change driven before a clock edge shows in the event register after the third rising clock edge, and not after the second.
- R7: Event bits stay set until software writes 1 to them at offset 0x0. Writing 0 to an event bit leaves it unchanged.
- R8: Event bits latch while their pin is masked. Unmasking a pin that has a pending event raises `irq_o` in the cycle after the mask write.
- R9: `irq_o` is high exactly while the AND of the event and mask registers is nonzero. It is a level that holds until the last unmasked event is cleared or masked.
- R10: When a new transition on a pin is recorded in the same cycle that software writes 1 to clear that pin's event, the event stays set.
- R11: After all ones are written to the event register and zero to the mask register, `irq_o` stays low while pins keep toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 32 | Raw pin levels, bit n is pin n |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data, pin 0 at bit 31 |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
A pin change is driven on a falling clock edge. Its event is due after the third rising edge that follows: two synchroniser stages, then the registered compare. So the bench samples one half-cycle after that edge, and also checks that the event is still clear after the second edge. Register writes take effect on the next rising edge. Reads and `irq_o` are combinational from the registers, so the bench checks them half a cycle after a write. For the simultaneous set-and-clear case, the clearing write is timed onto the third rising edge after the pin change.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;
  localparam int unsigned NPINS  = 32;
  localparam int unsigned ADDR_W = 4;

  typedef logic [NPINS-1:0] pin_vec_t;

  localparam logic [ADDR_W-1:0] OFF_EVENT = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_EDGE  = 4'h8;

  // register bit 31-n <-> pin n
  function automatic pin_vec_t bit_rev(input pin_vec_t v);
    pin_vec_t r;
    for (int i = 0; i < NPINS; i++) r[i] = v[NPINS-1-i];
    return r;
  endfunction

  // per-pin transition detect: fall_only picks falling-only vs any edge
  function automatic pin_vec_t edge_hit(input pin_vec_t prev, input pin_vec_t now,
                                        input pin_vec_t fall_only);
    return (fall_only & prev & ~now) | (~fall_only & (prev ^ now));
  endfunction

  function automatic logic irq_level(input pin_vec_t ev, input pin_vec_t en);
    return |(ev & en);
  endfunction
endpackage

// File: rtl/gpio_edge_irq_sync.sv
module gpio_edge_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_irq_detect.sv
module gpio_edge_irq_detect
  import gpio_edge_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_vec_t level_now,
  input  pin_vec_t fall_only,
  output pin_vec_t hit
);
  pin_vec_t level_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_prev <= '0;
    else        level_prev <= level_now;
  end

  assign hit = edge_hit(level_prev, level_now, fall_only);
endmodule

// File: rtl/gpio_edge_irq_regs.sv
module gpio_edge_irq_regs
  import gpio_edge_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  pin_vec_t          hit,
  output logic [NPINS-1:0]  rdata,
  output pin_vec_t          event_q,
  output pin_vec_t          mask_q,
  output pin_vec_t          fall_q,
  output pin_vec_t          clr_vec
);
  pin_vec_t wpin;
  logic     sel_ev, sel_mk, sel_ed;

  assign wpin    = bit_rev(wdata);
  assign sel_ev  = (addr == OFF_EVENT);
  assign sel_mk  = (addr == OFF_MASK);
  assign sel_ed  = (addr == OFF_EDGE);
  assign clr_vec = (we && sel_ev) ? wpin : '0;

  // new transitions take priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) event_q <= '0;
    else        event_q <= (event_q & ~clr_vec) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      fall_q <= '0;
    end else if (we) begin
      if (sel_mk) mask_q <= wpin;
      if (sel_ed) fall_q <= wpin;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ev)      rdata = bit_rev(event_q);
    else if (sel_mk) rdata = bit_rev(mask_q);
    else if (sel_ed) rdata = bit_rev(fall_q);
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  gpio_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  output logic              irq_o
);
  pin_vec_t sync_vec;
  pin_vec_t hit_vec;
  pin_vec_t ev_pin;
  pin_vec_t mask_pin;
  pin_vec_t fall_pin;
  pin_vec_t clr_vec;

  gpio_edge_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(gpio_in), .q_out(sync_vec)
  );

  gpio_edge_irq_detect u_det (
    .clk(clk), .rst_n(rst_n), .level_now(sync_vec), .fall_only(fall_pin), .hit(hit_vec)
  );

  gpio_edge_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hit(hit_vec), .rdata(reg_rdata), .event_q(ev_pin), .mask_q(mask_pin),
    .fall_q(fall_pin), .clr_vec(clr_vec)
  );

  assign irq_o = irq_level(ev_pin, mask_pin);
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_edge_irq_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     irq_o,
  input pin_vec_t ev_q,
  input pin_vec_t mask_q,
  input pin_vec_t fall_q,
  input pin_vec_t hit_vec,
  input pin_vec_t clr_vec,
  input pin_vec_t sync_vec
);
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((ev_q & mask_q) != '0)); // R9

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o); // R11

  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & fall_q & sync_vec) == '0); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q | ~$past(ev_q & ~clr_vec)) == '1)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & $past(hit_vec)) == $past(hit_vec))); // R10

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & $past(clr_vec & ~hit_vec)) == '0)); // R7
endmodule

bind gpio_edge_irq gpio_edge_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .ev_q(ev_pin), .mask_q(mask_pin),
  .fall_q(fall_pin), .hit_vec(hit_vec), .clr_vec(clr_vec), .sync_vec(sync_vec)
);

// File: tb/gpio_edge_irq_test.sv
`timescale 1ns/1ps
module gpio_edge_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] gpio_in = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_edge_irq uut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // {pin levels (bit n = pin n), expected event register (pin n at bit 31-n)}
  // edge select 0xFFFF0000: pins 0..15 falling only, pins 16..31 any edge
  localparam int NVEC = 8;
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0001, 32'h0000_0000},
    {32'h0000_0000, 32'h8000_0000},
    {32'h0001_0000, 32'h0000_8000},
    {32'h8000_0000, 32'h0000_8001},
    {32'h0000_FFFF, 32'h0000_0001},
    {32'hFFFF_0000, 32'hFFFF_FFFF},
    {32'hFFFF_0000, 32'h0000_0000},
    {32'h0000_0000, 32'h0000_FFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_pins(input logic [31:0] p);
    @(negedge clk);
    gpio_in = p;
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R3 reset values
    rd(4'h0, v); chk("R3 event", v, 32'h0);
    rd(4'h4, v); chk("R3 mask", v, 32'h0);
    rd(4'h8, v); chk("R3 edge", v, 32'h0);
    chk("R3 irq", {31'h0, irq_o}, 32'h0);

    // R2 register map and readback
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_0000);
    rd(4'h4, v); chk("R2 mask readback", v, 32'hFFFF_FFFF);
    rd(4'h8, v); chk("R2 edge readback", v, 32'hFFFF_0000);
    wr(4'hC, 32'h1234_5678);
    rd(4'hC, v); chk("R2 unmapped read", v, 32'h0);
    rd(4'h4, v); chk("R2 mask untouched", v, 32'hFFFF_FFFF);
    rd(4'h8, v); chk("R2 edge untouched", v, 32'hFFFF_0000);

    // R1 R4 R5 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      set_pins(VEC[i][63:32]);
      repeat (3) @(posedge clk);
      rd(4'h0, v); chk($sformatf("R1/R4/R5 vector %0d", i), v, VEC[i][31:0]);
      chk($sformatf("R9 irq vector %0d", i), {31'h0, irq_o}, {31'h0, VEC[i][31:0] != 0});
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, v); chk($sformatf("R7 cleared vector %0d", i), v, 32'h0);
    end

    // R6 latency: pin 20 (any edge) rises, bit 11
    set_pins(32'h0010_0000);
    repeat (2) @(posedge clk);
    rd(4'h0, v); chk("R6 not after two edges", v, 32'h0);
    @(posedge clk);
    rd(4'h0, v); chk("R6 set after three edges", v, 32'h0000_0800);

    // R7 writing zero keeps the event
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R7 write zero", v, 32'h0000_0800);
    chk("R9 irq held", {31'h0, irq_o}, 32'h1);

    // R10 clear in same cycle as a new edge on pin 20
    set_pins(32'h0);
    repeat (2) @(posedge clk);
    wr(4'h0, 32'h0000_0800);
    rd(4'h0, v); chk("R10 set wins", v, 32'h0000_0800);
    wr(4'h0, 32'h0000_0800);
    rd(4'h0, v); chk("R7 clear", v, 32'h0);
    chk("R9 irq drops", {31'h0, irq_o}, 32'h0);

    // R8 latch while masked, R1 pin 0 at bit 31
    wr(4'h4, 32'h0);
    set_pins(32'h0000_0001);
    set_pins(32'h0);          // pin 0 falls (falling-only mode)
    repeat (3) @(posedge clk);
    rd(4'h0, v); chk("R8 latched masked", v, 32'h8000_0000);
    chk("R8 irq low masked", {31'h0, irq_o}, 32'h0);
    wr(4'h4, 32'h4000_0000);
    chk("R1 other pin unmasked", {31'h0, irq_o}, 32'h0);
    wr(4'h4, 32'h8000_0000);
    chk("R8 irq on unmask", {31'h0, irq_o}, 32'h1);

    // R11 clear all, mask none, pins toggle
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h4, 32'h0);
    begin
      int hi = 0;
      for (int k = 0; k < 12; k++) begin
        set_pins((k % 2) ? 32'hFFFF_FFFF : 32'h0);
        if (irq_o) hi++;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      if (irq_o) hi++;
      chk("R11 irq stays low", hi, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule